// File: doc/BRIEF.md
# Sync/Reset Pulse Discriminator

This block watches an active-low input that serves two purposes: a short low pulse asks for conversion synchronization, and a long one asks for a device reset. The input is sampled on the master clock through two flops. The block then counts how many master clock cycles the level stays low and sorts each pulse into one of three classes: glitch, sync request or reset.

In continuous mode, the block compares the falling edge of a sync request with an internal data-rate tick, which has the same timing as data-ready. If the edge lands in the same cycle as the tick, the converter is already in step and nothing happens. If it lands in any other cycle, the block emits a one-cycle filter-reset pulse once the pulse has ended and its width is known. In chop mode the block does no alignment check. It emits a chop-restart pulse directly from the falling edge and does not wait for the pulse to end.

Timing convention used below: edge 1 is the first rising clock edge that samples `pin_n` low, and the pulse width `w` is the number of edges that sample it low.

Top module: `sync_pulse_discriminator`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `filt_rst`, `chop_restart` and `dev_rst` are all 0.
- R2: In continuous mode (`chop_mode` = 0), a pulse with `w` = 1 causes no output pulse.
- R3: In continuous mode, a pulse with 2 <= `w` < `RST_WIDTH` whose falling edge is aligned causes no output pulse. Aligned means `rate_tick` is 1 at edge 3.
- R4: In continuous mode, a pulse with 2 <= `w` < `RST_WIDTH` whose falling edge is misaligned causes exactly one `filt_rst` pulse, visible after edge `w`+3. Misaligned means `rate_tick` is 0 at edge 3.
- R5: A pulse with `w` >= `RST_WIDTH` causes exactly one `dev_rst` pulse, visible after edge `RST_WIDTH`+2, in either mode, and never causes a `filt_rst`.
- R6: When `chop_mode` = 1 at the falling edge, exactly one `chop_restart` pulse is visible after edge 3, whatever the width or `rate_tick`, and no `filt_rst` follows.
- R7: While `pin_n` stays high, `rate_tick` and `chop_mode` have no effect: all outputs stay 0.
- R8: Each of the three outputs is high for exactly one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pin_n | input | 1 | Asynchronous active-low sync/reset pin |
| chop_mode | input | 1 | 1 = chop mode (restart at falling edge), 0 = continuous mode |
| rate_tick | input | 1 | Internal data-rate tick, one cycle wide |
| filt_rst | output | 1 | One-cycle digital-filter reset request |
| chop_restart | output | 1 | One-cycle chop conversion restart |
| dev_rst | output | 1 | One-cycle device reset request |

## Verification
The bench builds the block with `RST_WIDTH` = 6. This puts the reset threshold within a few cycles, so one run covers every width class: single-cycle glitches, every width in the sync band, the exact threshold and widths beyond it. The data-rate tick is placed on the aligned edge, one edge early, one edge late or not at all. This separates the aligned case from the misaligned case at single-cycle resolution.

// File: rtl/sync_pulse_discriminator.sv
module sync_pulse_discriminator #(
  parameter int RST_WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic chop_mode,
  input  logic rate_tick,
  output logic filt_rst,
  output logic chop_restart,
  output logic dev_rst
);
  localparam int CW = $clog2(RST_WIDTH + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_WIDTH);

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic [CW-1:0] low_cnt;
  logic          aligned_q;
  logic          chop_q;

  wire lvl  = sync_q[1];
  wire fall = lvl_q & ~lvl;
  wire rise = ~lvl_q & lvl;

  wire [CW-1:0] cnt_nxt = lvl  ? '0 :
                          fall ? CW'(1) :
                          (low_cnt == LIM) ? LIM : low_cnt + 1'b1;

  wire in_sync_band = (low_cnt >= CW'(2)) && (low_cnt < LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q       <= 2'b11;
      lvl_q        <= 1'b1;
      low_cnt      <= '0;
      aligned_q    <= 1'b0;
      chop_q       <= 1'b0;
      filt_rst     <= 1'b0;
      chop_restart <= 1'b0;
      dev_rst      <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], pin_n};
      lvl_q   <= lvl;
      low_cnt <= cnt_nxt;
      if (fall) begin
        aligned_q <= rate_tick;
        chop_q    <= chop_mode;
      end
      chop_restart <= fall & chop_mode;
      dev_rst      <= ~lvl & (cnt_nxt == LIM) & (low_cnt != LIM);
      filt_rst     <= rise & ~chop_q & ~aligned_q & in_sync_band;
    end
  end
endmodule

// File: rtl/sync_pulse_discriminator_chk.sv
module sync_pulse_discriminator_chk #(
  parameter int RST_WIDTH = 32
) (
  input logic clk,
  input logic rst_n,
  input logic pin_n,
  input logic chop_mode,
  input logic rate_tick,
  input logic filt_rst,
  input logic chop_restart,
  input logic dev_rst
);
  a_r8_filt_single: assert property (@(posedge clk) disable iff (!rst_n)
    filt_rst |=> !filt_rst);
  a_r8_dev_single: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> !dev_rst);
  a_r8_chop_single: assert property (@(posedge clk) disable iff (!rst_n)
    chop_restart |=> !chop_restart);
  a_r4_filt_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    filt_rst |-> $past(pin_n, 3));
  a_r5_dev_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |-> !$past(pin_n, 3));
  a_r6_chop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    chop_restart |-> (!$past(pin_n, 3) && $past(pin_n, 4)));
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(filt_rst && chop_restart));
endmodule

bind sync_pulse_discriminator sync_pulse_discriminator_chk #(.RST_WIDTH(RST_WIDTH)) u_chk (.*);

// File: tb/sync_pulse_discriminator_test.sv
module sync_pulse_discriminator_test;
  localparam int RW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1;
  logic chop_mode = 1'b0;
  logic rate_tick = 1'b0;
  logic filt_rst, chop_restart, dev_rst;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sync_pulse_discriminator #(.RST_WIDTH(RW)) uut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .chop_mode(chop_mode),
    .rate_tick(rate_tick), .filt_rst(filt_rst), .chop_restart(chop_restart),
    .dev_rst(dev_rst));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_filt(input int w, input int tick, input bit chop);
    if (chop || w < 2 || w >= RW || tick == 3) return -1;
    return w + 3;
  endfunction

  function automatic int exp_dev(input int w);
    return (w >= RW) ? RW + 2 : -1;
  endfunction

  function automatic int exp_chop(input bit chop);
    return chop ? 3 : -1;
  endfunction

  function automatic string filt_tag(input int w, input int tick, input bit chop);
    if (chop) return "R6";
    if (w < 2) return "R2";
    if (w >= RW) return "R5";
    if (tick == 3) return "R3";
    return "R4";
  endfunction

  task automatic run_pulse(input int w, input int tick, input bit chop);
    int fc = 0, ff = -1, cc = 0, cf = -1, dc = 0, df = -1;
    int ef, ec, ed;
    chop_mode = chop;
    for (int j = 1; j <= w + 6; j++) begin
      pin_n = (j <= w) ? 1'b0 : 1'b1;
      rate_tick = (j == tick);
      @(posedge clk); #1;
      if (filt_rst)     begin fc++; if (ff < 0) ff = j; end
      if (chop_restart) begin cc++; if (cf < 0) cf = j; end
      if (dev_rst)      begin dc++; if (df < 0) df = j; end
    end
    pin_n = 1'b1;
    rate_tick = 1'b0;
    ef = exp_filt(w, tick, chop);
    ec = exp_chop(chop);
    ed = exp_dev(w);
    chk(fc == (ef < 0 ? 0 : 1), {filt_tag(w, tick, chop), "/R8"}, "filt_rst count", fc, ef < 0 ? 0 : 1);
    chk(ff == ef, filt_tag(w, tick, chop), "filt_rst edge", ff, ef);
    chk(cc == (ec < 0 ? 0 : 1) && cf == ec, "R6/R8", "chop_restart edge", cf, ec);
    chk(dc == (ed < 0 ? 0 : 1) && df == ed, "R5/R8", "dev_rst edge", df, ed);
  endtask

  task automatic gap(input int n);
    int spur = 0;
    for (int j = 0; j < n; j++) begin
      pin_n = 1'b1;
      rate_tick = 1'($urandom_range(1));
      chop_mode = 1'($urandom_range(1));
      @(posedge clk); #1;
      if (filt_rst || chop_restart || dev_rst) spur++;
    end
    rate_tick = 1'b0;
    chk(spur == 0, "R7", "outputs while pin high", spur, 0);
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (4) @(posedge clk);
    #1;
    chk(!filt_rst && !chop_restart && !dev_rst, "R1", "outputs in reset",
        {filt_rst, chop_restart, dev_rst}, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(!filt_rst && !chop_restart && !dev_rst, "R1", "outputs after release",
        {filt_rst, chop_restart, dev_rst}, 0);

    run_pulse(1, 3, 1'b0);  gap(4);
    run_pulse(1, 0, 1'b0);  gap(4);
    run_pulse(2, 3, 1'b0);  gap(4);
    run_pulse(2, 2, 1'b0);  gap(4);
    run_pulse(RW - 1, 4, 1'b0); gap(4);
    run_pulse(RW - 1, 3, 1'b0); gap(4);
    run_pulse(RW, 0, 1'b0); gap(4);
    run_pulse(RW, 3, 1'b0); gap(4);
    run_pulse(RW + 3, 2, 1'b0); gap(4);
    run_pulse(1, 0, 1'b1);  gap(4);
    run_pulse(3, 3, 1'b1);  gap(4);
    run_pulse(RW, 0, 1'b1); gap(4);

    for (int k = 0; k < 60; k++) begin
      int w, sel, t;
      w = 1 + $urandom_range(RW + 2);
      sel = $urandom_range(3);
      t = (sel == 0) ? 3 : (sel == 1) ? 2 : (sel == 2) ? 4 : 0;
      run_pulse(w, t, 1'($urandom_range(3) == 0));
      gap(4 + $urandom_range(4));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule